// File: doc/BRIEF.md
# Byte-Addressed Word Data Memory

A 1 KiB data store kept as 256 rows of 32-bit words and addressed in bytes. The row is taken from the byte address with its two lowest bits dropped. Whole words are stored and loaded at word-aligned addresses. A single byte can be loaded from any byte offset, and it is widened to 32 bits with sign or zero fill. Stores take effect on the rising clock edge. Loads are combinational from the current address.

A word access whose address is not word aligned raises an error flag, and a store at such an address is discarded. Address bits above bit 9 are ignored, so the 1 KiB window repeats across the whole address space. An active-low reset clears every row to zero.

Top module: `wordByteMem`

## Requirements
- R1: While and after reset (rstN low), every row reads back as 0x00000000.
- R2: With wordWrEn high and addr[1:0]==0, wrData is stored on the rising edge into row addr[9:2]. A word load (byteLoad low) at that address then returns it.
- R3: The row is addr[9:2]. Byte address 0x0 is row 0 and 0x4 is row 1. A store to one row leaves every other row unchanged.
- R4: Address bits [31:10] are ignored. Addresses that agree in bits [9:0] reach the same storage.
- R5: With byteLoad high, addr[1:0] picks the byte lane little-endian: 0 gives bits [7:0], 1 gives [15:8], 2 gives [23:16] and 3 gives [31:24]. That byte appears in rdData[7:0].
- R6: On a byte load, rdData[31:8] copies bit 7 of the selected byte when byteSigned is high, and is zero when byteSigned is low.
- R7: misaligned is high exactly when addr[1:0]!=0 and a word access is presented, meaning wordWrEn is high or byteLoad is low. A byte load without a store never raises it.
- R8: A store with misaligned high changes no memory content.
- R9: With wordWrEn low, no row changes. During a store cycle, rdData shows the old content of the row until the clock edge.
- R10: A misaligned word load returns the full word of row addr[9:2].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stores happen on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset; clears all rows |
| addr | input | ADDR_W (32) | Byte address |
| wrData | input | 32 | Word to store |
| wordWrEn | input | 1 | Word store request |
| byteLoad | input | 1 | High: byte load; low: word load |
| byteSigned | input | 1 | Sign-extend the byte load when high |
| rdData | output | 32 | Combinational load result |
| misaligned | output | 1 | Word access at an address with nonzero low bits |

## Verification
The bench builds the block with its default parameters: a 32-bit address and 256 rows. With the full 32-bit address, random addresses exercise the aliasing of the upper bits against the 10-bit window. With only 256 rows, random traffic revisits rows often, so stores are read back many times. Directed cases cover each byte lane with both fill modes, misaligned stores at each nonzero offset, and reads made during the store cycle.

// File: rtl/memPkg.sv
package memPkg;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;
  localparam int LANES  = DATA_W / BYTE_W;
  localparam int OFF_W  = $clog2(LANES);

  typedef struct packed {
    logic             wrStrobe;
    logic             byteSel;
    logic             signExt;
    logic [OFF_W-1:0] laneIdx;
  } memCtrl_t;
endpackage

// File: rtl/memCtrl.sv
module memCtrl
  import memPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [OFF_W-1:0] addrOff,
  input  logic             wordWrEn,
  input  logic             byteLoad,
  input  logic             byteSigned,
  output memCtrl_t         ctrl,
  output logic             misaligned
);
  logic offNonZero;
  logic wordAccess;

  assign offNonZero = |addrOff;
  assign wordAccess = wordWrEn | ~byteLoad;
  assign misaligned = wordAccess & offNonZero;

  always_comb begin
    ctrl.wrStrobe = wordWrEn & ~offNonZero;
    ctrl.byteSel  = byteLoad;
    ctrl.signExt  = byteSigned;
    ctrl.laneIdx  = addrOff;
  end

  // R8
  misalign_blocks_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    misaligned |-> !ctrl.wrStrobe);
endmodule

// File: rtl/memDatapath.sv
module memDatapath
  import memPkg::*;
#(
  parameter int ROWS  = 256,
  parameter int ROW_W = $clog2(ROWS)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ROW_W-1:0]  rowIdx,
  input  logic [DATA_W-1:0] wrData,
  input  memCtrl_t          ctrl,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] memArray [ROWS];
  logic [DATA_W-1:0] rowWord;
  logic [DATA_W-1:0] laneExt [LANES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ROWS; i++) memArray[i] <= '0;
    end else if (ctrl.wrStrobe) begin
      memArray[rowIdx] <= wrData;
    end
  end

  assign rowWord = memArray[rowIdx];

  for (genvar g = 0; g < LANES; g++) begin : laneGen
    assign laneExt[g] = {{(DATA_W-BYTE_W){ctrl.signExt & rowWord[BYTE_W*g+BYTE_W-1]}},
                         rowWord[BYTE_W*g +: BYTE_W]};
  end

  assign rdData = ctrl.byteSel ? laneExt[ctrl.laneIdx] : rowWord;

  // R2
  store_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wrStrobe |=> memArray[$past(rowIdx)] == $past(wrData));
  // R9
  idle_keeps_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.wrStrobe |=> memArray[$past(rowIdx)] == $past(rowWord));
endmodule

// File: rtl/wordByteMem.sv
module wordByteMem
  import memPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ROWS   = 256,
  localparam int ROW_W = $clog2(ROWS)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wordWrEn,
  input  logic              byteLoad,
  input  logic              byteSigned,
  output logic [DATA_W-1:0] rdData,
  output logic              misaligned
);
  memCtrl_t ctrl;

  memCtrl uCtrl (
    .clk(clk), .rstN(rstN), .addrOff(addr[OFF_W-1:0]),
    .wordWrEn(wordWrEn), .byteLoad(byteLoad), .byteSigned(byteSigned),
    .ctrl(ctrl), .misaligned(misaligned)
  );

  memDatapath #(.ROWS(ROWS)) uDp (
    .clk(clk), .rstN(rstN), .rowIdx(addr[OFF_W+ROW_W-1:OFF_W]),
    .wrData(wrData), .ctrl(ctrl), .rdData(rdData)
  );

  // R4
  addr_known_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(addr));
  // R6
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteLoad && !byteSigned) |-> rdData[DATA_W-1:BYTE_W] == '0);
  // R7
  byte_no_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteLoad && !wordWrEn) |-> !misaligned);
  // R8
  bad_store_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordWrEn && (|addr[OFF_W-1:0]) && !byteLoad) |=>
      (!$stable(addr) || byteLoad || rdData == $past(rdData)));
endmodule

// File: tb/sim_wordByteMem.sv
module sim_wordByteMem;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rstN = 0;
  logic [31:0] addr = 0, wrData = 0;
  logic wordWrEn = 0, byteLoad = 0, byteSigned = 0;
  logic [31:0] rdData;
  logic misaligned;
  logic [31:0] refMem [256];
  int checks = 0, errors = 0;
  bit done = 0;

  wordByteMem u0 (.clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
    .wordWrEn(wordWrEn), .byteLoad(byteLoad), .byteSigned(byteSigned),
    .rdData(rdData), .misaligned(misaligned));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] expRead(logic [31:0] a, logic bl, logic bs);
    logic [31:0] w = refMem[a[9:2]];
    logic [7:0] b = 8'(w >> (8 * a[1:0]));
    if (!bl) return w;
    return bs ? {{24{b[7]}}, b} : {24'h0, b};
  endfunction

  function automatic logic expMis(logic [31:0] a, logic we, logic bl);
    return (we || !bl) && (a[1:0] != 2'b00);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doOp(string tag, logic [31:0] a, logic [31:0] d,
                      logic we, logic bl, logic bs);
    @(negedge clk);
    addr = a; wrData = d; wordWrEn = we; byteLoad = bl; byteSigned = bs;
    #1;
    check({tag, " data"}, rdData, expRead(a, bl, bs));
    check({tag, " flag"}, {31'h0, misaligned}, {31'h0, expMis(a, we, bl)});
    @(posedge clk);
    if (we && a[1:0] == 2'b00) refMem[a[9:2]] = d;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20041101));
    for (int i = 0; i < 256; i++) refMem[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset row0", rdData, 32'h0);
    @(negedge clk); rstN = 1;
    doOp("R1 row255", 32'h3FC, 0, 0, 0, 0);
    doOp("R1 row1", 32'h4, 0, 0, 0, 0);
    doOp("R2 store row0", 32'h0, 32'h80FF7F01, 1, 0, 0);
    doOp("R3 store row1", 32'h4, 32'hCAFEF00D, 1, 0, 0);
    doOp("R2 load row0", 32'h0, 0, 0, 0, 0);
    doOp("R3 load row1", 32'h4, 0, 0, 0, 0);
    for (int l = 0; l < 4; l++) begin
      doOp("R5 lane unsigned", 32'(l), 0, 0, 1, 0);
      doOp("R6 lane signed", 32'(l), 0, 0, 1, 1);
    end
    doOp("R4 alias load", 32'hABCD0404, 0, 0, 0, 0);
    doOp("R4 alias store", 32'hFFFFFC08, 32'h12345678, 1, 0, 0);
    doOp("R4 alias readback", 32'h8, 0, 0, 0, 0);
    for (int o = 1; o < 4; o++) begin
      doOp("R7 R8 bad store", 32'h4 + 32'(o), 32'hDEADBEEF, 1, 0, 0);
      doOp("R8 row intact", 32'h4, 0, 0, 0, 0);
      doOp("R10 misaligned load", 32'h4 + 32'(o), 0, 0, 0, 0);
    end
    doOp("R7 byte no flag", 32'h3, 0, 0, 1, 1);
    doOp("R7 store byteLoad flag", 32'h6, 32'h1, 1, 1, 0);
    doOp("R9 idle write", 32'h0, 32'hFFFFFFFF, 0, 0, 0);
    doOp("R9 idle readback", 32'h0, 0, 0, 0, 0);
    doOp("R9 old during store", 32'h10, 32'h55AA55AA, 1, 0, 0);
    doOp("R9 new after store", 32'h10, 0, 0, 0, 0);
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a = $urandom;
      if ($urandom % 4 != 0) a[1:0] = 2'b00;
      doOp("RND R2 R5 R6 R7", a, $urandom, 1'($urandom % 2),
           1'($urandom % 2), 1'($urandom % 2));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule